// File: doc/BRIEF.md
# GPIO Port with Change Interrupt

This block is an 8-bit bidirectional general-purpose I/O port. Each pin can be an input or an output, chosen by its own bit in a direction register. Output pins drive the value held in an output latch. Input pins can have a weak pull-up, which one active-low control bit turns on for the whole port. The pad ring receives output-enable, output-value and pull-up-enable signals for each pin. It returns raw pin levels, and the block passes them through a two-flop synchronizer before any other logic uses them.

The upper four pins also feed a change detector. When software reads or writes the port register, the block stores those pins in a snapshot. Each later cycle, every upper pin that is an input is compared with its snapshot bit. Any difference sets a sticky change flag. While a difference remains, the flag is set again on every cycle, so software must access the port first and then clear the flag. An interrupt output is high while the flag is set and the change-interrupt enable is on.

Software uses a small register bus to reach the port register, the direction register and a control register. Register writes take effect on the clock edge. Read data is combinational in the same cycle as the access.

Top module: `gpio_chg_port`

## Requirements
- R1: After reset, the direction register reads 0xFF (all pins inputs), `pad_oe`, `pad_out`, `pad_pu` and `chg_irq` are all zero, and the control register reads 0x01 (pull-ups off, interrupt disabled, flag clear).
- R2: A write to the direction register (address 1) takes effect on the next clock edge. After it, each pin whose direction bit is 0 has `pad_oe` high, and each pin whose direction bit is 1 has `pad_oe` low.
- R3: A write to the port register (address 0) loads the output latch, and `pad_out` shows the latch from the next cycle on.
- R4: Control bit 0 is the active-low pull-up enable. When it is 0, `pad_pu` is high for every pin that is an input.
- R5: `pad_pu` is low for any pin that is an output, whatever the value of control bit 0.
- R6: A read of the port register returns the pin levels after the two-flop synchronizer.
- R7: When an upper-nibble pin (bits 7..4) that is an input differs from its snapshot bit, the change flag (control bit 2) is set on the next clock edge.
- R8: Level changes on pins 3..0 never set the change flag.
- R9: An upper-nibble pin configured as an output is left out of the comparison, so changing its level does not set the flag.
- R10: Writing 0 to control bit 2 while the mismatch still exists leaves the flag set, because setting takes priority over clearing.
- R11: After a read of the port register refreshes the snapshot, writing 0 to control bit 2 clears the flag. Writing 1 to that bit has no effect.
- R12: `chg_irq` is high only while the flag is set and control bit 1 (interrupt enable) is 1. The flag still sets when the enable is 0.
- R13: A write to the port register also refreshes the snapshot from the synchronized pins, so a later clear succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 port, 1 direction, 2 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| pad_in | input | 8 | Raw pin levels from the pads |
| pad_oe | output | 8 | Per-pin output driver enable |
| pad_out | output | 8 | Per-pin output value |
| pad_pu | output | 8 | Per-pin weak pull-up enable |
| chg_irq | output | 1 | Change interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit port, change detection on bits 7..4 and a two-stage synchronizer. With these settings it can reach both parts of the port: a lower nibble that must never affect the flag, and an upper nibble in which each pin can be switched between input and output. It can also make the clear request and the persisting mismatch happen in the same cycle, and check that a port write refreshes the snapshot just as a port read does.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
  typedef enum logic [1:0] {
    REG_PORT = 2'd0,
    REG_DIR  = 2'd1,
    REG_CTRL = 2'd2,
    REG_RSVD = 2'd3
  } reg_sel_e;

  localparam int CTRL_PUN_BIT  = 0;
  localparam int CTRL_IE_BIT   = 1;
  localparam int CTRL_FLAG_BIT = 2;
endpackage

// File: rtl/gpio_chg_sync.sv
module gpio_chg_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = d_in;
      end else begin : g_next
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_chg_regs.sv
module gpio_chg_regs
  import gpio_chg_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_sync,
  input  logic              flag,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  lat_q,
  output logic              pun_q,
  output logic              ie_q,
  output logic              port_acc,
  output logic              flag_clr
);
  logic             wr_port, wr_dir, wr_ctrl;
  logic [WIDTH-1:0] dir_d, lat_d;
  logic             pun_d, ie_d;

  always_comb begin
    wr_port  = bus_sel && bus_wr && (bus_addr == ADDR_W'(REG_PORT));
    wr_dir   = bus_sel && bus_wr && (bus_addr == ADDR_W'(REG_DIR));
    wr_ctrl  = bus_sel && bus_wr && (bus_addr == ADDR_W'(REG_CTRL));
    port_acc = bus_sel && (bus_addr == ADDR_W'(REG_PORT));
    flag_clr = wr_ctrl && !bus_wdata[CTRL_FLAG_BIT];
  end

  always_comb begin
    dir_d = dir_q;
    lat_d = lat_q;
    pun_d = pun_q;
    ie_d  = ie_q;
    if (wr_dir)  dir_d = bus_wdata;
    if (wr_port) lat_d = bus_wdata;
    if (wr_ctrl) begin
      pun_d = bus_wdata[CTRL_PUN_BIT];
      ie_d  = bus_wdata[CTRL_IE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      lat_q <= '0;
      pun_q <= 1'b1;
      ie_q  <= 1'b0;
    end else begin
      dir_q <= dir_d;
      lat_q <= lat_d;
      pun_q <= pun_d;
      ie_q  <= ie_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_W'(REG_PORT): bus_rdata = pin_sync;
      ADDR_W'(REG_DIR):  bus_rdata = dir_q;
      ADDR_W'(REG_CTRL): begin
        bus_rdata[CTRL_PUN_BIT]  = pun_q;
        bus_rdata[CTRL_IE_BIT]   = ie_q;
        bus_rdata[CTRL_FLAG_BIT] = flag;
      end
      default:           bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
  parameter int NBITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] pin_hi,
  input  logic [NBITS-1:0] dir_hi,
  input  logic             port_acc,
  input  logic             flag_clr,
  output logic             flag_q,
  output logic             mism
);
  logic [NBITS-1:0] snap_q, snap_d;
  logic [NBITS-1:0] diff;
  logic             flag_d;

  always_comb begin
    diff = (pin_hi ^ snap_q) & dir_hi;
    mism = |diff;
  end

  always_comb begin
    snap_d = snap_q;
    if (port_acc) snap_d = pin_hi;
    flag_d = flag_q;
    if (flag_clr) flag_d = 1'b0;
    if (mism)     flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      flag_q <= 1'b0;
    end else begin
      snap_q <= snap_d;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port #(
  parameter int WIDTH       = 8,
  parameter int CHG_LSB     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_pu,
  output logic              chg_irq
);
  localparam int CHG_N = WIDTH - CHG_LSB;

  logic             rst_meta_n, rst_int_n;
  logic [WIDTH-1:0] pin_sync, dir_q, lat_q;
  logic             pun_q, ie_q, port_acc, flag_clr, flag_q, chg_mism;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_int_n  <= rst_meta_n;
    end
  end

  gpio_chg_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_in  (pad_in),
    .d_out (pin_sync)
  );

  gpio_chg_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_sync  (pin_sync),
    .flag      (flag_q),
    .dir_q     (dir_q),
    .lat_q     (lat_q),
    .pun_q     (pun_q),
    .ie_q      (ie_q),
    .port_acc  (port_acc),
    .flag_clr  (flag_clr)
  );

  gpio_chg_detect #(.NBITS(CHG_N)) u_det (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pin_hi   (pin_sync[WIDTH-1:CHG_LSB]),
    .dir_hi   (dir_q[WIDTH-1:CHG_LSB]),
    .port_acc (port_acc),
    .flag_clr (flag_clr),
    .flag_q   (flag_q),
    .mism     (chg_mism)
  );

  always_comb begin
    pad_oe  = ~dir_q;
    pad_out = lat_q;
    pad_pu  = dir_q & {WIDTH{~pun_q}};
    chg_irq = flag_q && ie_q;
  end
endmodule

// File: rtl/gpio_chg_chk.sv
module gpio_chg_chk
  import gpio_chg_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic [WIDTH-1:0]  pad_oe,
  input logic [WIDTH-1:0]  pad_out,
  input logic [WIDTH-1:0]  pad_pu,
  input logic              chg_irq,
  input logic              flag,
  input logic              mism
);
  a_r2_oe_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == ADDR_W'(REG_DIR)) |=> (pad_oe == ~$past(bus_wdata)));

  a_r3_latch_drives_out: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == ADDR_W'(REG_PORT)) |=> (pad_out == $past(bus_wdata)));

  a_r5_no_pullup_on_output: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu & pad_oe) == '0));

  a_r7_mismatch_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    mism |=> flag);

  a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && mism && bus_sel && bus_wr && bus_addr == ADDR_W'(REG_CTRL)) |=> flag);

  a_r11_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> ($past(bus_sel && bus_wr && bus_addr == ADDR_W'(REG_CTRL)
                           && !bus_wdata[CTRL_FLAG_BIT]) && !$past(mism)));

  a_r12_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    chg_irq |-> flag);
endmodule

bind gpio_chg_port gpio_chg_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pad_oe    (pad_oe),
  .pad_out   (pad_out),
  .pad_pu    (pad_pu),
  .chg_irq   (chg_irq),
  .flag      (flag_q),
  .mism      (chg_mism)
);

// File: tb/tb_gpio_chg_port.sv
`timescale 1ns/1ps
module tb_gpio_chg_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic [7:0] pad_in = 8'h00, pad_oe, pad_out, pad_pu;
  logic       chg_irq;

  int   n_total = 0, n_fail = 0;
  bit   done = 1'b0;
  logic [7:0] exp_q[$];
  string      req_q[$];

  always #10 clk = ~clk;

  gpio_chg_port dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
    .chg_irq(chg_irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic read_expect(input logic [1:0] a, input logic [7:0] e, input string req);
    @(posedge clk); #2;
    exp_q.push_back(e); req_q.push_back(req);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); #2;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // monitor: pops expected read data mid-cycle
  always @(negedge clk) begin
    if (rst_n && bus_sel && !bus_wr && exp_q.size() > 0) begin
      check(req_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_total++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    idle(3); rst_n = 1'b1; idle(4);
    @(negedge clk);
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_out", pad_out, 8'h00);
    check("R1 pad_pu", pad_pu, 8'h00);
    check("R1 irq", {7'd0, chg_irq}, 8'h00);
    read_expect(2'd1, 8'hFF, "R1 dir");
    read_expect(2'd2, 8'h01, "R1 ctrl");
    read_expect(2'd0, 8'h00, "R6 port at reset");

    bus_write(2'd2, 8'h03);            // enable irq, pull-ups off
    pad_in = 8'h05; idle(5);
    read_expect(2'd2, 8'h03, "R8 lower nibble ignored");
    @(negedge clk); check("R8 irq", {7'd0, chg_irq}, 8'h00);

    pad_in = 8'h15; idle(5);
    read_expect(2'd2, 8'h07, "R7 flag set");
    @(negedge clk); check("R12 irq on", {7'd0, chg_irq}, 8'h01);

    bus_write(2'd2, 8'h03); idle(1);   // clear while mismatch remains
    read_expect(2'd2, 8'h07, "R10 set beats clear");

    read_expect(2'd0, 8'h15, "R6 port read");
    bus_write(2'd2, 8'h07); idle(1);   // writing 1 to flag: no effect
    read_expect(2'd2, 8'h07, "R11 write one ignored");
    bus_write(2'd2, 8'h03); idle(1);
    read_expect(2'd2, 8'h03, "R11 clear after read");
    @(negedge clk); check("R11 irq off", {7'd0, chg_irq}, 8'h00);

    bus_write(2'd2, 8'h01);            // irq disabled
    pad_in = 8'h35; idle(5);
    read_expect(2'd2, 8'h05, "R12 flag with irq disabled");
    @(negedge clk); check("R12 irq gated", {7'd0, chg_irq}, 8'h00);

    bus_write(2'd0, 8'hA0);            // port write refreshes snapshot
    bus_write(2'd2, 8'h01); idle(1);
    read_expect(2'd2, 8'h01, "R13 write refresh then clear");

    bus_write(2'd1, 8'h0F);
    @(negedge clk);
    check("R2 pad_oe", pad_oe, 8'hF0);
    check("R3 pad_out", pad_out, 8'hA0);
    check("R5 pu off while disabled", pad_pu, 8'h00);
    pad_in = 8'hF5; idle(5);
    read_expect(2'd2, 8'h01, "R9 output pins excluded");

    bus_write(2'd2, 8'h00);            // pull-ups on
    @(negedge clk); check("R5 pu only inputs", pad_pu, 8'h0F);
    bus_write(2'd1, 8'hFF);
    @(negedge clk);
    check("R4 pu all inputs", pad_pu, 8'hFF);
    check("R2 all inputs", pad_oe, 8'h00);
    read_expect(2'd1, 8'hFF, "R2 dir readback");
    idle(2);
    check("scoreboard drained", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule